// File: doc/BRIEF.md
# PWM Event Action Qualifier

This block turns time-base events into two pulse-width-modulated outputs. An external time base supplies the counter value, its direction, a per-count enable (`tick`) and flags marking the zero and period points. The block holds the two compare thresholds, compares the counter against them, and tags each match as rising or falling. For every output a 12-bit control word picks what each of six events does: nothing, drive low, drive high or toggle. When events coincide a fixed priority decides. The order depends on whether the time base counts up only or counts up and down.

The compare thresholds and the continuous software force are double-buffered. A write lands in a shadow copy, which moves into the active copy at a selectable load point. An immediate mode bypasses the shadow copy. Software can also apply a single action to an output at any clock edge. It can also hold an output high or low on every count until the force is withdrawn. Dead-band shaping and fault tripping sit downstream and are not part of this block.

Top module: `pwm_event_qualifier`

## Requirements
- R1: While `rst_n` is low both outputs are low, both compare thresholds are zero and no continuous force is active.
- R2: On a `tick`, the winning event applies the 2-bit field of its output's control word: 00 leave, 01 drive low, 10 drive high, 11 invert. Field positions are [1:0] zero, [3:2] period, [5:4] compare-A rising, [7:6] compare-A falling, [9:8] compare-B rising, [11:10] compare-B falling.
- R3: In up-count mode (`mode_ud`=0), coincident events resolve as period over compare-B rising over compare-A rising over zero. An event whose field is 00 does not block a lower-priority event.
- R4: In up-count mode falling compare events never fire, and a compare match counts as rising whatever `ctr_up` says. In up-down mode (`mode_ud`=1) a match is rising when `ctr_up`=1 and falling when `ctr_up`=0.
- R5: In up-down mode, coincident events resolve as compare-B over compare-A over period over zero. As in R3, a 00 field does not block a lower-priority event.
- R6: With `cmp_imm`=0 a compare write (`cmp_wr` bit 0 for A, bit 1 for B) goes to the shadow copy. The active copy takes the shadow value on a tick that meets `load_sel`: 00 zero, 01 period, 10 zero or period, 11 never.
- R7: With `cmp_imm`=1 a compare write updates the active threshold at that clock edge. This takes precedence over a load in the same cycle.
- R8: Compare events match the counter against the active threshold only. A value still waiting in the shadow copy never produces a match.
- R9: A `sw_stb` pulse applies `sw_act_a`/`sw_act_b` (same encoding as R2) at that clock edge, whether or not `tick` is high. It overrides any event action in the same cycle.
- R10: The continuous force per output is 00 off, 01 hold low, 10 hold high, 11 off. An active force sets the output on every tick and overrides both events and a same-cycle one-shot action. It has no effect between ticks.
- R11: With `frc_imm`=1 a force write (`frc_wr`) becomes active at once and governs the very next tick. With `frc_imm`=0 it waits in a shadow copy until a load point per `load_sel`, and governs the ticks after that load.
- R12: The outputs change only on a clock edge where `tick` or `sw_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base count enable; events count only when high |
| mode_ud | input | 1 | 0 up-count, 1 up-down count |
| ctr | input | CTR_W | Time-base counter value |
| ctr_up | input | 1 | Counter direction, 1 rising |
| evt_zero | input | 1 | Counter is at zero |
| evt_prd | input | 1 | Counter is at period |
| load_sel | input | 2 | Shadow load point: 00 zero, 01 period, 10 either, 11 never |
| cmp_imm | input | 1 | Compare writes bypass the shadow copy |
| cmp_wr | input | 2 | Compare write strobes, bit 0 A, bit 1 B |
| cmp_wdata | input | CTR_W | Compare write value |
| ctl_a | input | 12 | Event action word for output A |
| ctl_b | input | 12 | Event action word for output B |
| sw_stb | input | 1 | One-shot software action strobe |
| sw_act_a | input | 2 | One-shot action for output A |
| sw_act_b | input | 2 | One-shot action for output B |
| frc_imm | input | 1 | Force writes bypass the shadow copy |
| frc_wr | input | 1 | Continuous force write strobe |
| frc_a | input | 2 | Continuous force code for output A |
| frc_b | input | 2 | Continuous force code for output B |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The outputs are compared every cycle against a reference model. The model is fed by a bench time base that runs both as a sawtooth and as a triangle. Setting compare thresholds equal to the period or to zero makes events coincide, which shows whether the priority order is right in each mode. Giving some winners a 00 field shows whether silent events are passed over. A triangle with separate rising and falling fields tells the two compare directions apart. An up-count run with the direction input held low tests that falling events are suppressed in that mode. Ticks interleaved with idle cycles, and one-shot strobes that land both on and between ticks, separate tick-gated behaviour from immediate behaviour. Shadow writes under each load selection, including "never", show when the active values move.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int unsigned CTL_W = 12;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    LD_ZERO   = 2'b00,
    LD_PERIOD = 2'b01,
    LD_EITHER = 2'b10,
    LD_NEVER  = 2'b11
  } load_e;

  // bit i of this struct matches field i of the control word
  typedef struct packed {
    logic cbd;
    logic cbu;
    logic cad;
    logic cau;
    logic prd;
    logic zro;
  } evt_t;

  function automatic logic [1:0] pick_act(logic hit, logic [1:0] fld, logic [1:0] prev);
    return (hit && (fld != ACT_NONE)) ? fld : prev;
  endfunction

  function automatic logic apply_act(logic cur, logic [1:0] a);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         imm,
  input  logic         load,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] active
);

  logic [W-1:0] shadow_q;
  logic [W-1:0] shadow_d;
  logic [W-1:0] active_q;
  logic [W-1:0] active_d;
  logic         shadow_en;
  logic         active_en;

  always_comb begin
    shadow_en = wr & ~imm;
    shadow_d  = wdata;
    active_en = (wr & imm) | load;
    active_d  = (wr & imm) ? wdata : shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (shadow_en) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (active_en) begin
      active_q <= active_d;
    end
  end

  assign active = active_q;

endmodule

// File: rtl/pwm_evt_decode.sv
module pwm_evt_decode
  import pwm_aq_pkg::*;
#(
  parameter int unsigned CTR_W = 16
) (
  input  logic             tick,
  input  logic             mode_ud,
  input  logic [CTR_W-1:0] ctr,
  input  logic             ctr_up,
  input  logic             evt_zero,
  input  logic             evt_prd,
  input  logic [1:0]       load_sel,
  input  logic [CTR_W-1:0] cmpa,
  input  logic [CTR_W-1:0] cmpb,
  output evt_t             evts,
  output logic             load
);

  logic rising;
  logic falling;
  logic hit_a;
  logic hit_b;

  always_comb begin
    // up-count mode treats every match as rising
    rising   = ~mode_ud | ctr_up;
    falling  = mode_ud & ~ctr_up;
    hit_a    = tick & (ctr == cmpa);
    hit_b    = tick & (ctr == cmpb);
    evts.zro = tick & evt_zero;
    evts.prd = tick & evt_prd;
    evts.cau = hit_a & rising;
    evts.cad = hit_a & falling;
    evts.cbu = hit_b & rising;
    evts.cbd = hit_b & falling;
  end

  always_comb begin
    case (load_e'(load_sel))
      LD_ZERO:   load = tick & evt_zero;
      LD_PERIOD: load = tick & evt_prd;
      LD_EITHER: load = tick & (evt_zero | evt_prd);
      default:   load = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwm_out_qual.sv
module pwm_out_qual
  import pwm_aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mode_ud,
  input  evt_t             evts,
  input  logic [CTL_W-1:0] ctl,
  input  logic             sw_stb,
  input  logic [1:0]       sw_act,
  input  logic [1:0]       frc,
  output logic             pwm
);

  logic [1:0] evt_act;
  logic       pwm_q;
  logic       pwm_d;
  logic       pwm_en;

  // chain runs lowest priority first, so later hits override
  always_comb begin
    evt_act = ACT_NONE;
    evt_act = pick_act(evts.zro, ctl[1:0], evt_act);
    if (mode_ud) begin
      evt_act = pick_act(evts.prd, ctl[3:2],   evt_act);
      evt_act = pick_act(evts.cau, ctl[5:4],   evt_act);
      evt_act = pick_act(evts.cad, ctl[7:6],   evt_act);
      evt_act = pick_act(evts.cbu, ctl[9:8],   evt_act);
      evt_act = pick_act(evts.cbd, ctl[11:10], evt_act);
    end else begin
      evt_act = pick_act(evts.cau, ctl[5:4],   evt_act);
      evt_act = pick_act(evts.cbu, ctl[9:8],   evt_act);
      evt_act = pick_act(evts.prd, ctl[3:2],   evt_act);
    end
  end

  always_comb begin
    pwm_en = tick | sw_stb;
    pwm_d  = pwm_q;
    if (tick) begin
      pwm_d = apply_act(pwm_q, evt_act);
    end
    if (sw_stb && (sw_act != ACT_NONE)) begin
      pwm_d = apply_act(pwm_q, sw_act);
    end
    if (tick && (frc == 2'b01)) begin
      pwm_d = 1'b0;
    end
    if (tick && (frc == 2'b10)) begin
      pwm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else if (pwm_en) begin
      pwm_q <= pwm_d;
    end
  end

  assign pwm = pwm_q;

endmodule

// File: rtl/pwm_event_qualifier.sv
module pwm_event_qualifier
  import pwm_aq_pkg::*;
#(
  parameter int unsigned CTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mode_ud,
  input  logic [CTR_W-1:0] ctr,
  input  logic             ctr_up,
  input  logic             evt_zero,
  input  logic             evt_prd,
  input  logic [1:0]       load_sel,
  input  logic             cmp_imm,
  input  logic [1:0]       cmp_wr,
  input  logic [CTR_W-1:0] cmp_wdata,
  input  logic [11:0]      ctl_a,
  input  logic [11:0]      ctl_b,
  input  logic             sw_stb,
  input  logic [1:0]       sw_act_a,
  input  logic [1:0]       sw_act_b,
  input  logic             frc_imm,
  input  logic             frc_wr,
  input  logic [1:0]       frc_a,
  input  logic [1:0]       frc_b,
  output logic             pwm_a,
  output logic             pwm_b
);

  localparam int unsigned N_OUT = 2;
  localparam int unsigned FRC_W = 2 * N_OUT;

  logic [CTR_W-1:0]            cmpa_act;
  logic [CTR_W-1:0]            cmpb_act;
  logic [FRC_W-1:0]            frc_act;
  logic                        load;
  evt_t                        evts;
  logic [N_OUT-1:0][CTL_W-1:0] ctl_v;
  logic [N_OUT-1:0][1:0]       sw_v;
  logic [N_OUT-1:0]            pwm_v;

  assign ctl_v = {ctl_b, ctl_a};
  assign sw_v  = {sw_act_b, sw_act_a};

  pwm_shadow_reg #(.W(CTR_W)) u_cmpa (
    .clk(clk), .rst_n(rst_n), .wr(cmp_wr[0]), .imm(cmp_imm),
    .load(load), .wdata(cmp_wdata), .active(cmpa_act)
  );

  pwm_shadow_reg #(.W(CTR_W)) u_cmpb (
    .clk(clk), .rst_n(rst_n), .wr(cmp_wr[1]), .imm(cmp_imm),
    .load(load), .wdata(cmp_wdata), .active(cmpb_act)
  );

  pwm_shadow_reg #(.W(FRC_W)) u_force (
    .clk(clk), .rst_n(rst_n), .wr(frc_wr), .imm(frc_imm),
    .load(load), .wdata({frc_b, frc_a}), .active(frc_act)
  );

  pwm_evt_decode #(.CTR_W(CTR_W)) u_dec (
    .tick(tick), .mode_ud(mode_ud), .ctr(ctr), .ctr_up(ctr_up),
    .evt_zero(evt_zero), .evt_prd(evt_prd), .load_sel(load_sel),
    .cmpa(cmpa_act), .cmpb(cmpb_act), .evts(evts), .load(load)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    pwm_out_qual u_qual (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode_ud(mode_ud),
      .evts(evts), .ctl(ctl_v[o]), .sw_stb(sw_stb), .sw_act(sw_v[o]),
      .frc(frc_act[2*o +: 2]), .pwm(pwm_v[o])
    );
  end

  assign pwm_a = pwm_v[0];
  assign pwm_b = pwm_v[1];

endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk #(
  parameter int unsigned CTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             sw_stb,
  input logic             cmp_imm,
  input logic [1:0]       cmp_wr,
  input logic [CTR_W-1:0] cmp_wdata,
  input logic             load,
  input logic [CTR_W-1:0] cmpa_act,
  input logic [3:0]       frc_act,
  input logic             pwm_a,
  input logic             pwm_b
);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sw_stb) |=> ($stable(pwm_a) && $stable(pwm_b)));

  assert_force_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_act[1:0] == 2'b10) |=> pwm_a);

  assert_force_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_act[3:2] == 2'b01) |=> !pwm_b);

  assert_imm_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_imm && cmp_wr[0]) |=> (cmpa_act == $past(cmp_wdata)));

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_imm && !load) |=> $stable(cmpa_act));

endmodule

bind pwm_event_qualifier pwm_aq_chk #(.CTR_W(CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sw_stb(sw_stb),
  .cmp_imm(cmp_imm), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
  .load(load), .cmpa_act(cmpa_act), .frc_act(frc_act),
  .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/pwm_event_qualifier_tb.sv
module pwm_event_qualifier_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        mode_ud;
  logic [15:0] ctr;
  logic        ctr_up;
  logic        evt_zero;
  logic        evt_prd;
  logic [1:0]  load_sel;
  logic        cmp_imm;
  logic [1:0]  cmp_wr;
  logic [15:0] cmp_wdata;
  logic [11:0] ctl_a;
  logic [11:0] ctl_b;
  logic        sw_stb;
  logic [1:0]  sw_act_a;
  logic [1:0]  sw_act_b;
  logic        frc_imm;
  logic        frc_wr;
  logic [1:0]  frc_a;
  logic [1:0]  frc_b;
  logic        pwm_a;
  logic        pwm_b;

  pwm_event_qualifier u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_ud(mode_ud), .ctr(ctr),
    .ctr_up(ctr_up), .evt_zero(evt_zero), .evt_prd(evt_prd),
    .load_sel(load_sel), .cmp_imm(cmp_imm), .cmp_wr(cmp_wr),
    .cmp_wdata(cmp_wdata), .ctl_a(ctl_a), .ctl_b(ctl_b), .sw_stb(sw_stb),
    .sw_act_a(sw_act_a), .sw_act_b(sw_act_b), .frc_imm(frc_imm),
    .frc_wr(frc_wr), .frc_a(frc_a), .frc_b(frc_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    run_cmp = 0;
  bit    done = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [1:0]  m_out;
  logic [15:0] m_ca, m_ca_sh, m_cb, m_cb_sh;
  logic [3:0]  m_f, m_f_sh;

  function automatic logic [1:0] resolve(input logic [11:0] c, input logic [5:0] h, input logic ud);
    int ord[6];
    int n;
    if (ud) begin ord = '{5, 4, 3, 2, 1, 0}; n = 6; end
    else    begin ord = '{1, 4, 2, 0, 0, 0}; n = 4; end
    for (int k = 0; k < n; k++) begin
      if (h[ord[k]] && c[2*ord[k] +: 2] != 2'b00) return c[2*ord[k] +: 2];
    end
    return 2'b00;
  endfunction

  function automatic logic do_act(input logic cur, input logic [1:0] a);
    if (a == 2'd1) return 1'b0;
    if (a == 2'd2) return 1'b1;
    if (a == 2'd3) return ~cur;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [5:0]  h;
    logic        ld, up_ok, ma, mb, nv;
    logic [11:0] c;
    logic [1:0]  s, f;
    if (!rst_n) begin
      m_out <= '0; m_ca <= '0; m_ca_sh <= '0; m_cb <= '0; m_cb_sh <= '0;
      m_f <= '0; m_f_sh <= '0;
    end else begin
      up_ok = !mode_ud || ctr_up;
      ma = tick && (ctr == m_ca);
      mb = tick && (ctr == m_cb);
      h = {mb && mode_ud && !ctr_up, mb && up_ok, ma && mode_ud && !ctr_up, ma && up_ok,
           tick && evt_prd, tick && evt_zero};
      ld = tick && ((load_sel == 2'd0 && evt_zero) || (load_sel == 2'd1 && evt_prd) ||
                    (load_sel == 2'd2 && (evt_zero || evt_prd)));
      for (int o = 0; o < 2; o++) begin
        c  = (o == 0) ? ctl_a : ctl_b;
        s  = (o == 0) ? sw_act_a : sw_act_b;
        f  = m_f[2*o +: 2];
        nv = m_out[o];
        if (tick) nv = do_act(m_out[o], resolve(c, h, mode_ud));
        if (sw_stb && s != 2'b00) nv = do_act(m_out[o], s);
        if (tick && f == 2'd1) nv = 1'b0;
        if (tick && f == 2'd2) nv = 1'b1;
        m_out[o] <= nv;
      end
      if (cmp_imm && cmp_wr[0]) m_ca <= cmp_wdata; else if (ld) m_ca <= m_ca_sh;
      if (cmp_imm && cmp_wr[1]) m_cb <= cmp_wdata; else if (ld) m_cb <= m_cb_sh;
      if (!cmp_imm && cmp_wr[0]) m_ca_sh <= cmp_wdata;
      if (!cmp_imm && cmp_wr[1]) m_cb_sh <= cmp_wdata;
      if (frc_imm && frc_wr) m_f <= {frc_b, frc_a}; else if (ld) m_f <= m_f_sh;
      if (!frc_imm && frc_wr) m_f_sh <= {frc_b, frc_a};
    end
  end

  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk(cur_req, "pwm_a", pwm_a, m_out[0]);
      chk(cur_req, "pwm_b", pwm_b, m_out[1]);
    end
  end

  // ---------------- time base ----------------
  int bc = 0;
  int prd_v = 7;
  bit bup = 1'b1;
  bit up_dir_lvl = 1'b1;

  task automatic tb_step(input bit en);
    @(negedge clk);
    sw_stb = 1'b0; cmp_wr = 2'b00; frc_wr = 1'b0;
    tick = en;
    if (en) begin
      if (mode_ud) begin
        if (bc == 0) bup = 1'b1;
        else if (bc == prd_v) bup = 1'b0;
      end else begin
        bup = up_dir_lvl;
      end
      ctr = 16'(bc); ctr_up = bup;
      evt_zero = (bc == 0); evt_prd = (bc == prd_v);
      if (mode_ud) bc = bup ? bc + 1 : bc - 1;
      else bc = (bc == prd_v) ? 0 : bc + 1;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tb_step(1'b1);
  endtask

  task automatic wr_cmp(input logic [1:0] which, input logic [15:0] v);
    tb_step(1'b0);
    cmp_wr = which; cmp_wdata = v;
  endtask

  task automatic wr_frc(input logic [1:0] fa, input logic [1:0] fb);
    tb_step(1'b0);
    frc_wr = 1'b1; frc_a = fa; frc_b = fb;
  endtask

  task automatic set_base(input bit ud, input int p);
    mode_ud = ud; prd_v = p; bc = 0; bup = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; tick = 0; mode_ud = 0; ctr = 0; ctr_up = 1; evt_zero = 0; evt_prd = 0;
    load_sel = 2'd0; cmp_imm = 1; cmp_wr = 0; cmp_wdata = 0; ctl_a = 0; ctl_b = 0;
    sw_stb = 0; sw_act_a = 0; sw_act_b = 0; frc_imm = 1; frc_wr = 0; frc_a = 0; frc_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pwm_a after reset", pwm_a, 1'b0);
    chk("R1", "pwm_b after reset", pwm_b, 1'b0);
    run_cmp = 1;

    // R2: action codes and field layout, up count
    cur_req = "R2";
    set_base(0, 7);
    wr_cmp(2'b01, 16'd3); wr_cmp(2'b10, 16'd5);
    ctl_a = 12'h012; ctl_b = 12'h303;
    run(30);

    // R12: idle cycles between ticks hold the outputs
    cur_req = "R12";
    for (int i = 0; i < 30; i++) tb_step(i % 2 == 0);

    // R3: up-count priority with coincident events
    cur_req = "R3";
    wr_cmp(2'b01, 16'd7); wr_cmp(2'b10, 16'd7);
    ctl_a = 12'h236; ctl_b = 12'h232;
    run(24);
    wr_cmp(2'b01, 16'd0);
    ctl_a = 12'h021; ctl_b = 12'h201;
    run(24);

    // R4: direction tagging and falling events suppressed in up-count mode
    cur_req = "R4";
    up_dir_lvl = 1'b0;
    wr_cmp(2'b01, 16'd3);
    ctl_a = 12'h080; ctl_b = 12'h032;
    run(20);
    up_dir_lvl = 1'b1;
    set_base(1, 8);
    wr_cmp(2'b01, 16'd4); wr_cmp(2'b10, 16'd6);
    ctl_a = 12'h060; ctl_b = 12'h300;
    run(40);

    // R5: up-down priority
    cur_req = "R5";
    wr_cmp(2'b01, 16'd8); wr_cmp(2'b10, 16'd8);
    ctl_a = 12'hC48; ctl_b = 12'h048;
    run(36);
    wr_cmp(2'b01, 16'd0); wr_cmp(2'b10, 16'd3);
    ctl_a = 12'h212; ctl_b = 12'h0E1;
    run(36);

    // R6: shadow compare loads under each load selection
    cur_req = "R6";
    set_base(0, 9);
    cmp_imm = 0;
    ctl_a = 12'h012; ctl_b = 12'h102;
    for (int ls = 0; ls < 4; ls++) begin
      load_sel = 2'(ls);
      wr_cmp(2'b01, 16'(2 + ls)); run(5);
      wr_cmp(2'b10, 16'(8 - ls)); run(25);
    end

    // R8: a pending shadow value never matches
    cur_req = "R8";
    load_sel = 2'd3;
    wr_cmp(2'b11, 16'd1);
    run(25);
    load_sel = 2'd0;
    run(25);

    // R7: immediate write, also against a same-cycle load
    cur_req = "R7";
    cmp_imm = 1;
    wr_cmp(2'b01, 16'd6); run(12);
    tb_step(1'b1);
    while (!evt_zero) tb_step(1'b1);
    cmp_wr = 2'b10; cmp_wdata = 16'd2;
    run(20);

    // R9: one-shot action on and between ticks
    cur_req = "R9";
    for (int i = 0; i < 60; i++) begin
      tb_step(i % 3 != 0);
      if (i % 5 == 2) begin
        sw_stb = 1'b1;
        sw_act_a = 2'((i / 5) % 4);
        sw_act_b = 2'(3 - (i / 5) % 4);
      end
    end

    // R10: continuous force codes, immediate mode
    cur_req = "R10";
    frc_imm = 1;
    wr_frc(2'b10, 2'b01);
    for (int i = 0; i < 20; i++) begin
      tb_step(i % 2 == 0);
      if (i % 4 == 1) begin sw_stb = 1'b1; sw_act_a = 2'b01; sw_act_b = 2'b10; end
    end
    wr_frc(2'b11, 2'b00); run(20);
    wr_frc(2'b01, 2'b10); run(10);

    // R11: force via shadow, loaded at the period point
    cur_req = "R11";
    frc_imm = 0; load_sel = 2'd1;
    wr_frc(2'b10, 2'b10); run(4);
    wr_frc(2'b00, 2'b01); run(25);
    load_sel = 2'd2;
    wr_frc(2'b01, 2'b00); run(25);

    tb_step(1'b0);
    run_cmp = 0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule